// File: doc/BRIEF.md
# UART Channel Diagnostic Mode Router

This block sits between one UART receive engine, one UART transmit engine, the CPU-side data and status paths, and the two serial pins. A 2-bit mode input picks how the channel is wired. In normal operation the two engines are independent. In local loopback the transmitter is fed back into the receiver and the line stays quiet. In the two echo modes the line input is retimed and driven straight back out on the transmit pin.

The echo path is built into the router. It runs from the receive oversampling tick. It finds a start bit, samples each bit at its centre and replays every bit one bit time later. Parity and stop bits are replayed exactly as they arrived. A received break keeps the transmit pin low until the next valid start bit. The router also masks transmitter status in the echo modes and hides the receive stream and its errors from the CPU in remote loopback. The shift engines, the baud generator and the FIFOs are outside this block.

Top module: `uart_mode_router`

## Requirements
- R1: While reset is asserted, `txd_pin` is 1, `mode_o` is 00, and `tx_can_load_o`, `tx_drained_o` and `rx_err_o` are all 0.
- R2: The mode encodings are 00 normal, 01 automatic echo, 10 local loopback and 11 remote loopback. `mode_o` takes the value of `mode_req` on a clock edge only when `tx_idle` and `rx_idle` are both 1 at that edge. Otherwise it holds.
- R3: In mode 00, `txd_pin` equals `tx_eng_dout` one clock later. The receive engine gets `rxd_pin` and `rx_os_tick`, and the transmit engine gets `tx_os_tick`. The CPU data paths and the parity and framing check enables pass through unchanged. The three status outputs equal their inputs one clock later.
- R4: In modes 01 and 11 the echo path watches `rxd_pin` on clock edges where `rx_os_tick` is 1. A low line starts a character. The start bit is sampled OS_RATE/2 ticks after that and must still be low. The remaining DATA_BITS+PARITY_EN+1 bits are sampled every OS_RATE ticks after it. The value sampled for each bit is driven on `txd_pin` OS_RATE ticks after its sample, plus one clock. Parity and stop bits are replayed as sampled.
- R5: In modes 01 and 11, `tx_can_load_o` and `tx_drained_o` are 0 one clock later. `cpu_tx_ready` and `tx_eng_valid` are 0, and `tx_eng_tick` follows `rx_os_tick`.
- R6: In mode 01 the parity and framing check enables are 1. The receive data handshake passes between engine and CPU unchanged, and `rx_err_o` equals `rx_err_in` one clock later.
- R7: In mode 10, `rx_eng_din` equals `tx_eng_dout` and `rx_eng_tick` equals `tx_os_tick`. `txd_pin` is 1 one clock later, whatever `rxd_pin` does. Both CPU data paths pass through unchanged.
- R8: In mode 11, `cpu_rx_valid` is 0 and `rx_eng_ready` is 1, so received characters are discarded. Both check enables are 0, and `rx_err_o` is 0 one clock later.
- R9: If the stop bit of an echoed character samples low, `txd_pin` stays 0 until a later valid start bit. This holds after the line returns high. A low pulse that is high again at its OS_RATE/2 sample is a false start and does not release the hold.
- R10: When the mode is neither 01 nor 11, the echo path returns to idle. On entering an echo mode, `txd_pin` is 1 until a new character is echoed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 2 | Requested channel mode |
| tx_idle | input | 1 | Transmit engine has nothing in progress |
| rx_idle | input | 1 | Receive engine has nothing in progress |
| mode_o | output | 2 | Mode in effect |
| rxd_pin | input | 1 | Serial line input |
| txd_pin | output | 1 | Serial line output |
| rx_os_tick | input | 1 | Receive oversampling tick |
| tx_os_tick | input | 1 | Transmit oversampling tick |
| rx_eng_tick | output | 1 | Tick delivered to the receive engine |
| tx_eng_tick | output | 1 | Tick delivered to the transmit engine |
| rx_eng_din | output | 1 | Serial data delivered to the receive engine |
| tx_eng_dout | input | 1 | Serial data produced by the transmit engine |
| rx_par_chk_en | output | 1 | Receive engine parity check enable |
| rx_frm_chk_en | output | 1 | Receive engine framing check enable |
| tx_can_load_in | input | 1 | Transmit engine can accept a character |
| tx_drained_in | input | 1 | Transmit engine is completely empty |
| rx_err_in | input | ERR_W | Receive error flags from the engine |
| tx_can_load_o | output | 1 | Gated transmit-ready status |
| tx_drained_o | output | 1 | Gated transmit-empty status |
| rx_err_o | output | ERR_W | Gated receive error flags |
| rx_eng_valid | input | 1 | Receive engine has a character |
| rx_eng_data | input | DATA_BITS | Received character |
| rx_eng_ready | output | 1 | Character taken from the receive engine |
| cpu_rx_valid | output | 1 | Character offered to the CPU |
| cpu_rx_data | output | DATA_BITS | Character offered to the CPU |
| cpu_rx_ready | input | 1 | CPU takes the character |
| cpu_tx_valid | input | 1 | CPU offers a character to send |
| cpu_tx_data | input | DATA_BITS | Character to send |
| cpu_tx_ready | output | 1 | Character accepted from the CPU |
| tx_eng_valid | output | 1 | Character offered to the transmit engine |
| tx_eng_data | output | DATA_BITS | Character offered to the transmit engine |
| tx_eng_ready | input | 1 | Transmit engine takes the character |

## Verification
The bench builds the router with DATA_BITS=5, PARITY_EN=1, OS_RATE=8 and ERR_W=3. Each echoed character is then eight bits and 64 clocks long. That leaves room for several echoed characters in both echo modes, two breaks, a false start inside a break hold, and an exit from and re-entry into echo. The short bit time puts the centre sample four ticks after the falling edge, so a two-clock glitch falls well short of it and tests the false-start rule. The receive tick runs on every clock during echo tests, so the bench can place every replayed bit on an exact clock. The other tests drive ticks at random.

// File: rtl/uart_mode_router.sv
module uart_mode_router #(
  parameter int DATA_BITS = 8,
  parameter int PARITY_EN = 1,
  parameter int OS_RATE   = 16,
  parameter int ERR_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_req,
  input  logic                 tx_idle,
  input  logic                 rx_idle,
  output logic [1:0]           mode_o,
  input  logic                 rxd_pin,
  output logic                 txd_pin,
  input  logic                 rx_os_tick,
  input  logic                 tx_os_tick,
  output logic                 rx_eng_tick,
  output logic                 tx_eng_tick,
  output logic                 rx_eng_din,
  input  logic                 tx_eng_dout,
  output logic                 rx_par_chk_en,
  output logic                 rx_frm_chk_en,
  input  logic                 tx_can_load_in,
  input  logic                 tx_drained_in,
  input  logic [ERR_W-1:0]     rx_err_in,
  output logic                 tx_can_load_o,
  output logic                 tx_drained_o,
  output logic [ERR_W-1:0]     rx_err_o,
  input  logic                 rx_eng_valid,
  input  logic [DATA_BITS-1:0] rx_eng_data,
  output logic                 rx_eng_ready,
  output logic                 cpu_rx_valid,
  output logic [DATA_BITS-1:0] cpu_rx_data,
  input  logic                 cpu_rx_ready,
  input  logic                 cpu_tx_valid,
  input  logic [DATA_BITS-1:0] cpu_tx_data,
  output logic                 cpu_tx_ready,
  output logic                 tx_eng_valid,
  output logic [DATA_BITS-1:0] tx_eng_data,
  input  logic                 tx_eng_ready
);

  localparam int FRAME_BITS = DATA_BITS + PARITY_EN + 2;
  localparam int CW = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] MID_CNT  = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OS_RATE - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  localparam logic [1:0] M_NORM   = 2'b00;
  localparam logic [1:0] M_LOCAL  = 2'b10;
  localparam logic [1:0] M_REMOTE = 2'b11;

  typedef enum logic [1:0] {E_HUNT, E_START, E_FRAME, E_BREAK} echo_st_t;

  logic [1:0]    mode_q;
  logic          echo_on, is_local, is_remote;
  echo_st_t      est;
  logic [CW-1:0] os_cnt, fl_cnt;
  logic [BW-1:0] bit_idx;
  logic          held, echo_q, fl_pend, txd_q;

  assign echo_on   = mode_q[0];
  assign is_local  = (mode_q == M_LOCAL);
  assign is_remote = (mode_q == M_REMOTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= M_NORM;
    else if (tx_idle && rx_idle)
      mode_q <= mode_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est     <= E_HUNT;
      os_cnt  <= '0;
      bit_idx <= '0;
      held    <= 1'b1;
      echo_q  <= 1'b1;
      fl_pend <= 1'b0;
      fl_cnt  <= '0;
    end else if (!echo_on) begin
      est     <= E_HUNT;
      os_cnt  <= '0;
      bit_idx <= '0;
      held    <= 1'b1;
      echo_q  <= 1'b1;
      fl_pend <= 1'b0;
      fl_cnt  <= '0;
    end else if (rx_os_tick) begin
      if (fl_pend) begin
        if (fl_cnt == LAST_CNT) begin
          echo_q  <= held;
          fl_pend <= 1'b0;
        end else begin
          fl_cnt <= fl_cnt + CW'(1);
        end
      end
      unique case (est)
        E_HUNT: begin
          if (!rxd_pin) begin
            est    <= E_START;
            os_cnt <= '0;
          end
        end
        E_START: begin
          if (os_cnt == MID_CNT) begin
            os_cnt <= '0;
            if (!rxd_pin) begin
              echo_q  <= held;
              held    <= rxd_pin;
              fl_pend <= 1'b0;
              bit_idx <= BW'(1);
              est     <= E_FRAME;
            end else begin
              est <= E_HUNT;
            end
          end else begin
            os_cnt <= os_cnt + CW'(1);
          end
        end
        E_FRAME: begin
          if (os_cnt == LAST_CNT) begin
            os_cnt  <= '0;
            echo_q  <= held;
            held    <= rxd_pin;
            if (bit_idx == LAST_BIT) begin
              fl_pend <= 1'b1;
              fl_cnt  <= '0;
              est     <= rxd_pin ? E_HUNT : E_BREAK;
            end else begin
              fl_pend <= 1'b0;
              bit_idx <= bit_idx + BW'(1);
            end
          end else begin
            os_cnt <= os_cnt + CW'(1);
          end
        end
        E_BREAK: begin
          if (rxd_pin) est <= E_HUNT;
        end
        default: est <= E_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q         <= 1'b1;
      tx_can_load_o <= 1'b0;
      tx_drained_o  <= 1'b0;
      rx_err_o      <= '0;
    end else begin
      unique case (mode_q)
        M_NORM:  txd_q <= tx_eng_dout;
        M_LOCAL: txd_q <= 1'b1;
        default: txd_q <= echo_q;
      endcase
      tx_can_load_o <= tx_can_load_in & ~echo_on;
      tx_drained_o  <= tx_drained_in & ~echo_on;
      rx_err_o      <= is_remote ? '0 : rx_err_in;
    end
  end

  assign mode_o        = mode_q;
  assign txd_pin       = txd_q;
  assign rx_eng_tick   = is_local ? tx_os_tick : rx_os_tick;
  assign tx_eng_tick   = echo_on ? rx_os_tick : tx_os_tick;
  assign rx_eng_din    = is_local ? tx_eng_dout : rxd_pin;
  assign rx_par_chk_en = ~is_remote;
  assign rx_frm_chk_en = ~is_remote;

  assign cpu_rx_valid  = rx_eng_valid & ~is_remote;
  assign cpu_rx_data   = rx_eng_data;
  assign rx_eng_ready  = is_remote | cpu_rx_ready;

  assign cpu_tx_ready  = tx_eng_ready & ~echo_on;
  assign tx_eng_valid  = cpu_tx_valid & ~echo_on;
  assign tx_eng_data   = cpu_tx_data;

endmodule

module uart_mode_router_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_idle,
  input logic             rx_idle,
  input logic [1:0]       mode_o,
  input logic             txd_pin,
  input logic             tx_can_load_o,
  input logic             tx_drained_o,
  input logic [ERR_W-1:0] rx_err_o
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (txd_pin && mode_o == 2'b00 && !tx_can_load_o && !tx_drained_o && rx_err_o == '0));

  // R2
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> ($past(tx_idle) && $past(rx_idle)));

  // R5
  echo_txstat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[0] |=> (!tx_can_load_o && !tx_drained_o));

  // R7
  local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |=> txd_pin);

  // R8
  remote_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |=> (rx_err_o == '0));

endmodule

bind uart_mode_router uart_mode_router_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_idle(tx_idle), .rx_idle(rx_idle),
  .mode_o(mode_o), .txd_pin(txd_pin), .tx_can_load_o(tx_can_load_o),
  .tx_drained_o(tx_drained_o), .rx_err_o(rx_err_o)
);

// File: tb/uart_mode_router_tb.sv
`timescale 1ns/1ps
module uart_mode_router_tb;
  localparam int DB = 5;
  localparam int OS = 8;
  localparam int EW = 3;
  localparam int NB = DB + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic tx_idle = 1'b1, rx_idle = 1'b1;
  logic [1:0] mode_o;
  logic rxd_pin = 1'b1, txd_pin;
  logic rx_os_tick = 1'b0, tx_os_tick = 1'b0, rx_eng_tick, tx_eng_tick, rx_eng_din;
  logic tx_eng_dout = 1'b1, rx_par_chk_en, rx_frm_chk_en;
  logic tx_can_load_in = 1'b0, tx_drained_in = 1'b0;
  logic [EW-1:0] rx_err_in = '0, rx_err_o;
  logic tx_can_load_o, tx_drained_o;
  logic rx_eng_valid = 1'b0, rx_eng_ready, cpu_rx_valid, cpu_rx_ready = 1'b0;
  logic [DB-1:0] rx_eng_data = '0, cpu_rx_data, cpu_tx_data = '0, tx_eng_data;
  logic cpu_tx_valid = 1'b0, cpu_tx_ready, tx_eng_valid, tx_eng_ready = 1'b0;

  always #10 clk = ~clk;

  uart_mode_router #(.DATA_BITS(DB), .PARITY_EN(1), .OS_RATE(OS), .ERR_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .tx_idle(tx_idle), .rx_idle(rx_idle),
    .mode_o(mode_o), .rxd_pin(rxd_pin), .txd_pin(txd_pin), .rx_os_tick(rx_os_tick),
    .tx_os_tick(tx_os_tick), .rx_eng_tick(rx_eng_tick), .tx_eng_tick(tx_eng_tick),
    .rx_eng_din(rx_eng_din), .tx_eng_dout(tx_eng_dout), .rx_par_chk_en(rx_par_chk_en),
    .rx_frm_chk_en(rx_frm_chk_en), .tx_can_load_in(tx_can_load_in), .tx_drained_in(tx_drained_in),
    .rx_err_in(rx_err_in), .tx_can_load_o(tx_can_load_o), .tx_drained_o(tx_drained_o),
    .rx_err_o(rx_err_o), .rx_eng_valid(rx_eng_valid), .rx_eng_data(rx_eng_data),
    .rx_eng_ready(rx_eng_ready), .cpu_rx_valid(cpu_rx_valid), .cpu_rx_data(cpu_rx_data),
    .cpu_rx_ready(cpu_rx_ready), .cpu_tx_valid(cpu_tx_valid), .cpu_tx_data(cpu_tx_data),
    .cpu_tx_ready(cpu_tx_ready), .tx_eng_valid(tx_eng_valid), .tx_eng_data(tx_eng_data),
    .tx_eng_ready(tx_eng_ready)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0, rx_rand = 1, tick_rand = 1;
  string txd_tag = "R3";

  logic [1:0] m_mode = 2'b00;
  logic m_echo = 1'b1, x_txd = 1'b1, x_load = 1'b0, x_drain = 1'b0;
  logic [EW-1:0] x_err = '0;
  int ev_c[$];
  logic ev_v[$];

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, nm, act, exp, cyc);
    end
  endtask

  function automatic string rx_tag(input logic [1:0] m);
    case (m) 2'b00: return "R3"; 2'b01: return "R6"; 2'b10: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic string tx_tag(input logic [1:0] m);
    case (m) 2'b00: return "R3"; 2'b10: return "R7"; default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 2'b00; m_echo = 1'b1; x_txd = 1'b1;
      x_load = 1'b0; x_drain = 1'b0; x_err = '0;
      ev_c.delete(); ev_v.delete();
    end else begin
      x_txd   = (m_mode == 2'b00) ? tx_eng_dout : (m_mode == 2'b10) ? 1'b1 : m_echo;
      x_load  = m_mode[0] ? 1'b0 : tx_can_load_in;
      x_drain = m_mode[0] ? 1'b0 : tx_drained_in;
      x_err   = (m_mode == 2'b11) ? '0 : rx_err_in;
      if (m_mode[0]) begin
        while (ev_c.size() > 0 && ev_c[0] <= cyc) begin
          m_echo = ev_v[0];
          void'(ev_c.pop_front());
          void'(ev_v.pop_front());
        end
      end else begin
        m_echo = 1'b1;
        ev_c.delete(); ev_v.delete();
      end
      if (tx_idle && rx_idle) m_mode = mode_req;
    end
    #5;
    if (!rst_n) begin
      chk("R1", "txd_pin", 32'(txd_pin), 32'd1);
      chk("R1", "mode_o", 32'(mode_o), 32'd0);
      chk("R1", "status", {tx_can_load_o, tx_drained_o, rx_err_o}, 32'd0);
    end else begin
      chk("R2", "mode_o", 32'(mode_o), 32'(m_mode));
      chk(txd_tag, "txd_pin", 32'(txd_pin), 32'(x_txd));
      chk(tx_tag(m_mode), "tx_can_load_o", 32'(tx_can_load_o), 32'(x_load));
      chk(tx_tag(m_mode), "tx_drained_o", 32'(tx_drained_o), 32'(x_drain));
      chk(rx_tag(m_mode), "rx_err_o", 32'(rx_err_o), 32'(x_err));
    end
    chk(rx_tag(m_mode), "rx_eng_tick", 32'(rx_eng_tick), 32'((m_mode == 2'b10) ? tx_os_tick : rx_os_tick));
    chk(tx_tag(m_mode), "tx_eng_tick", 32'(tx_eng_tick), 32'(m_mode[0] ? rx_os_tick : tx_os_tick));
    chk(rx_tag(m_mode), "rx_eng_din", 32'(rx_eng_din), 32'((m_mode == 2'b10) ? tx_eng_dout : rxd_pin));
    chk(rx_tag(m_mode), "chk_en", {rx_par_chk_en, rx_frm_chk_en}, (m_mode == 2'b11) ? 32'd0 : 32'd3);
    chk(rx_tag(m_mode), "cpu_rx_valid", 32'(cpu_rx_valid), 32'((m_mode == 2'b11) ? 1'b0 : rx_eng_valid));
    chk(rx_tag(m_mode), "cpu_rx_data", 32'(cpu_rx_data), 32'(rx_eng_data));
    chk(rx_tag(m_mode), "rx_eng_ready", 32'(rx_eng_ready), 32'((m_mode == 2'b11) ? 1'b1 : cpu_rx_ready));
    chk(tx_tag(m_mode), "cpu_tx_ready", 32'(cpu_tx_ready), 32'(m_mode[0] ? 1'b0 : tx_eng_ready));
    chk(tx_tag(m_mode), "tx_eng_valid", 32'(tx_eng_valid), 32'(m_mode[0] ? 1'b0 : cpu_tx_valid));
    chk(tx_tag(m_mode), "tx_eng_data", 32'(tx_eng_data), 32'(cpu_tx_data));
  end

  task automatic step(input logic rv);
    @(negedge clk);
    rxd_pin        = rx_rand ? 1'($urandom) : rv;
    rx_os_tick     = tick_rand ? 1'($urandom) : 1'b1;
    tx_os_tick     = 1'($urandom);
    tx_eng_dout    = 1'($urandom);
    tx_can_load_in = 1'($urandom);
    tx_drained_in  = 1'($urandom);
    rx_err_in      = EW'($urandom);
    rx_eng_valid   = 1'($urandom);
    rx_eng_data    = DB'($urandom);
    cpu_rx_ready   = 1'($urandom);
    cpu_tx_valid   = 1'($urandom);
    cpu_tx_data    = DB'($urandom);
    tx_eng_ready   = 1'($urandom);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b1);
  endtask

  // R4: bit i sampled at P0+OS/2+OS*i appears on txd after edge P0+OS/2+OS*(i+1)+1
  task automatic send_frame(input logic [15:0] bits, input int n);
    int p0;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < OS; j++) begin
        step(bits[i]);
        if (i == 0 && j == 0) begin
          p0 = cyc + 1;
          for (int k = 0; k < n; k++) begin
            ev_c.push_back(p0 + OS / 2 + OS * (k + 1));
            ev_v.push_back(bits[k]);
          end
        end
      end
    end
  endtask

  function automatic logic [15:0] mk_frame(input logic [DB-1:0] d);
    logic [15:0] b = '0;
    b[DB:1]   = d;
    b[DB + 1] = ^d;
    b[DB + 2] = 1'b1;
    return b;
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_req = m;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    idle(5);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: normal mode with random traffic
    idle(200);
    // R2: mode request refused while the receiver is busy
    @(negedge clk);
    mode_req = 2'b01; rx_idle = 1'b0;
    idle(20);
    chk("R2", "mode held while busy", 32'(mode_o), 32'd0);
    @(negedge clk);
    tx_idle = 1'b0; rx_idle = 1'b1;
    idle(10);
    chk("R2", "mode held while tx busy", 32'(mode_o), 32'd0);
    @(negedge clk);
    tx_idle = 1'b1;
    idle(3);
    chk("R2", "mode applied when idle", 32'(mode_o), 32'd1);
    // R4 / R5 / R6: automatic echo
    rx_rand = 0; tick_rand = 0; txd_tag = "R4";
    idle(2 * OS);
    for (int f = 0; f < 4; f++) begin
      send_frame(mk_frame(DB'($urandom)), NB);
      idle(2 * OS);
    end
    send_frame(mk_frame(DB'(5'b10110)) & ~16'(1 << (DB + 1)) | 16'(1 << (DB + 1)), NB);
    idle(2 * OS);
    // R8 / R9: remote loopback, break hold and false start
    set_mode(2'b11);
    chk("R8", "remote mode", 32'(mode_o), 32'd3);
    send_frame(mk_frame(DB'($urandom)), NB);
    idle(2 * OS);
    txd_tag = "R9";
    send_frame(16'h0000, NB);
    for (int k = 0; k < 2 * OS; k++) step(1'b0);
    idle(3 * OS);
    chk("R9", "txd held low after break", 32'(txd_pin), 32'd0);
    step(1'b0); step(1'b0);
    idle(2 * OS);
    chk("R9", "false start keeps hold", 32'(txd_pin), 32'd0);
    send_frame(mk_frame(DB'(5'b01101)), NB);
    idle(2 * OS);
    chk("R9", "released by valid start", 32'(txd_pin), 32'd1);
    send_frame(16'h0000, NB);
    idle(3 * OS);
    chk("R9", "second break held", 32'(txd_pin), 32'd0);
    // R10: leaving the echo modes clears the held break
    txd_tag = "R10";
    set_mode(2'b00);
    set_mode(2'b01);
    idle(OS);
    chk("R10", "echo restarts idle high", 32'(txd_pin), 32'd1);
    txd_tag = "R4";
    send_frame(mk_frame(DB'($urandom)), NB);
    idle(2 * OS);
    // R7: local loopback with random line input
    rx_rand = 1; tick_rand = 1; txd_tag = "R7";
    set_mode(2'b10);
    chk("R7", "local mode", 32'(mode_o), 32'd2);
    idle(200);
    txd_tag = "R3";
    set_mode(2'b00);
    idle(50);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule